// File: doc/BRIEF.md
# SPI Status Register Controller

This block is the serial front end of a device status register. It watches an SPI bus in mode 0 (clock idles low, input sampled on the rising clock edge, output changed on the falling edge). It decodes three instructions: one that reads the 8-bit status word, one that writes it, and one that arms a write-enable latch. The bus pins are oversampled by the system clock. Each instruction begins when chip select falls. An instruction that is cut short, or that carries the wrong number of bits, is dropped without changing any state.

The status word holds a write-protect-enable flag and two block-protect bits. These three bits are the only ones that software can write, and they are brought out as ports for downstream protection logic. The word also reports the write-enable latch and a ready flag. The ready flag mirrors a busy input from an external store and recall engine. The write-status instruction is refused unless the write-enable latch is set, and a successful write clears the latch again.

Top module: `spi_status_ctl`

## Requirements
- R1: After reset the status word reads 0x00, `protBp` and `protWpen` are 0, and `spiMisoOe` is 0.
- R2: Every chip-select fall (`spiCsN` going low) restarts instruction decoding from the first bit, even if an earlier instruction was left unfinished. `spiMosi` is sampled on rising `spiSck` and `spiMiso` changes on falling `spiSck`.
- R3: Status bit 0 reads 1 when `storeBusy` is high at the moment the word is loaded for output, and 0 otherwise. No instruction can write it.
- R4: Opcode 0x05, sent MSB first, returns the status word MSB first in the 8 clock periods after the opcode. The status word is laid out as: bit 7 = write-protect enable, bits 6..4 = 0, bit 3 = block-protect high, bit 2 = block-protect low, bit 1 = write-enable latch, bit 0 = ready/busy.
- R5: `spiMisoOe` is high only while those 8 status bits are being driven. It is low during every opcode and after the eighth status bit.
- R6: Opcode 0x06 followed by chip-select rise after exactly 8 bits sets the write-enable latch (status bit 1).
- R7: Opcode 0x01 followed by exactly 8 data bits, with chip-select rise after bit 16 and the latch set, copies data bits 7, 3 and 2 into the status word. Bits 6..4 stay 0, and bits 1 and 0 are not taken from the data.
- R8: A write-status instruction issued while the latch is 0 leaves the status word unchanged.
- R9: A successful write-status instruction clears the write-enable latch.
- R10: A write-enable or write-status instruction whose chip-select rises after any bit count other than 8 or 16 respectively changes no state.
- R11: Any other opcode changes no state and never enables `spiMiso`.
- R12: `protBp` equals {status bit 3, status bit 2} and `protWpen` equals status bit 7 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| spiSck | input | 1 | Serial clock, idles low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data into the block |
| storeBusy | input | 1 | High while the external store/recall engine is busy |
| spiMiso | output | 1 | Serial data out of the block |
| spiMisoOe | output | 1 | Output enable for `spiMiso`; low means high impedance |
| protBp | output | 2 | Block-protect bits {high, low} |
| protWpen | output | 1 | Write-protect enable bit |

## Verification
The embedded assertions check several things on every cycle. The protection bits never change while the latch is clear, and any change of them coincides with the latch falling. The ready bit is captured from the busy input when the output word loads. The unused bits load as zero. The output enable is confined to the read window and drops when chip select rises. A chip-select fall restarts the bit count. The following can only be shown by the bench scenarios:
- the exact serial order and timing of the returned word;
- that truncated or over-long frames and unknown opcodes leave the register untouched;
- the full write mask, swept across all 256 data values.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ_STAT  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRITE_STAT = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WRITE_EN   = 8'h06;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_READ,
    PH_WDATA,
    PH_WEN,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic setWen;
    logic commit;
  } dp_strobe_t;

endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  output logic sckRise,
  output logic sckFall,
  output logic csFall,
  output logic csRise,
  output logic siSync
);

  logic [STAGES:0]   sckPipe;
  logic [STAGES:0]   csPipe;
  logic [STAGES-1:0] siPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[STAGES-1:0], sckIn};
      csPipe  <= {csPipe[STAGES-1:0], csNIn};
      siPipe  <= {siPipe[STAGES-2:0], siIn};
    end
  end

  assign sckRise = sckPipe[STAGES-1] & ~sckPipe[STAGES];
  assign sckFall = ~sckPipe[STAGES-1] & sckPipe[STAGES];
  assign csFall  = ~csPipe[STAGES-1] & csPipe[STAGES];
  assign csRise  = csPipe[STAGES-1] & ~csPipe[STAGES];
  assign siSync  = siPipe[STAGES-1];

endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csFall,
  input  logic              csRise,
  input  logic              siSync,
  input  logic [BYTE_W-2:0] rxTail,
  input  logic              wenQ,
  output dp_strobe_t        strb,
  output logic              misoOe
);

  localparam int unsigned CNT_MAX = 2 * BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned OUT_W   = $clog2(BYTE_W + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [OUT_W-1:0]  outCnt;
  logic              oeQ;
  logic              live;
  logic [BYTE_W-1:0] opcode;

  assign live   = !csFall && !csRise;
  assign opcode = {rxTail, siSync};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      outCnt <= '0;
      oeQ    <= 1'b0;
    end else if (csFall) begin
      phase  <= PH_OPCODE;
      bitCnt <= '0;
      outCnt <= '0;
      oeQ    <= 1'b0;
    end else if (csRise) begin
      phase  <= PH_IDLE;
      oeQ    <= 1'b0;
    end else begin
      if (sckRise && phase != PH_IDLE) begin
        if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
        if (phase == PH_OPCODE && bitCnt == CNT_W'(BYTE_W - 1)) begin
          case (opcode)
            OP_READ_STAT:  phase <= PH_READ;
            OP_WRITE_STAT: phase <= PH_WDATA;
            OP_WRITE_EN:   phase <= PH_WEN;
            default:       phase <= PH_SKIP;
          endcase
        end
      end
      if (sckFall && phase == PH_READ) begin
        if (outCnt < OUT_W'(BYTE_W)) begin
          outCnt <= outCnt + 1'b1;
          oeQ    <= 1'b1;
        end else begin
          oeQ    <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.rxShift = live && sckRise && phase != PH_IDLE;
    strb.txLoad  = live && sckFall && phase == PH_READ && outCnt == '0;
    strb.txShift = live && sckFall && phase == PH_READ && outCnt != '0
                   && outCnt < OUT_W'(BYTE_W);
    strb.setWen  = csRise && phase == PH_WEN && bitCnt == CNT_W'(BYTE_W);
    strb.commit  = csRise && phase == PH_WDATA && bitCnt == CNT_W'(2 * BYTE_W) && wenQ;
  end

  assign misoOe = oeQ;

  AST_OE_IN_READ:   assert property (@(posedge clk) disable iff (!rstN) misoOe |-> phase == PH_READ);   // R5
  AST_OE_OFF_CS:    assert property (@(posedge clk) disable iff (!rstN) csRise |=> !misoOe);            // R5
  AST_CS_RESTART:   assert property (@(posedge clk) disable iff (!rstN) csFall |=> bitCnt == '0);       // R2
  AST_SKIP_SILENT:  assert property (@(posedge clk) disable iff (!rstN) phase == PH_SKIP |-> !strb.commit && !strb.setWen && !misoOe); // R11

endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic              siSync,
  input  logic              busyIn,
  output logic [BYTE_W-2:0] rxTail,
  output logic              txMsb,
  output logic              wenQ,
  output logic [1:0]        bpOut,
  output logic              wpenOut
);

  logic [BYTE_W-1:0] rxReg;
  logic [BYTE_W-1:0] txReg;
  logic [1:0]        bpQ;
  logic              wpenQ;
  logic [BYTE_W-1:0] statusWord;

  assign statusWord = {wpenQ, 3'b000, bpQ, wenQ, busyIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      bpQ   <= '0;
      wpenQ <= 1'b0;
      wenQ  <= 1'b0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[BYTE_W-2:0], siSync};
      if (strb.txLoad)       txReg <= statusWord;
      else if (strb.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (strb.commit) begin
        wpenQ <= rxReg[7];
        bpQ   <= rxReg[3:2];
        wenQ  <= 1'b0;
      end else if (strb.setWen) begin
        wenQ  <= 1'b1;
      end
    end
  end

  assign rxTail  = rxReg[BYTE_W-2:0];
  assign txMsb   = txReg[BYTE_W-1];
  assign bpOut   = bpQ;
  assign wpenOut = wpenQ;

  AST_LOCKED_HOLD:  assert property (@(posedge clk) disable iff (!rstN) !wenQ |=> $stable({wpenQ, bpQ}));        // R8
  AST_WEN_DROP:     assert property (@(posedge clk) disable iff (!rstN) !$stable({wpenQ, bpQ}) |-> $fell(wenQ)); // R9
  AST_RDY_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN) strb.txLoad |=> txReg[0] == $past(busyIn)); // R3
  AST_UNUSED_ZERO:  assert property (@(posedge clk) disable iff (!rstN) strb.txLoad |=> txReg[6:4] == 3'b000);   // R4

endmodule

// File: rtl/spi_status_ctl.sv
module spi_status_ctl
  import spi_stat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSck,
  input  logic       spiCsN,
  input  logic       spiMosi,
  input  logic       storeBusy,
  output logic       spiMiso,
  output logic       spiMisoOe,
  output logic [1:0] protBp,
  output logic       protWpen
);

  logic              sckRise;
  logic              sckFall;
  logic              csFall;
  logic              csRise;
  logic              siSync;
  logic [BYTE_W-2:0] rxTail;
  logic              wenQ;
  dp_strobe_t        strb;

  spi_stat_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .sckIn   (spiSck),
    .csNIn   (spiCsN),
    .siIn    (spiMosi),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .csFall  (csFall),
    .csRise  (csRise),
    .siSync  (siSync)
  );

  spi_stat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .csFall  (csFall),
    .csRise  (csRise),
    .siSync  (siSync),
    .rxTail  (rxTail),
    .wenQ    (wenQ),
    .strb    (strb),
    .misoOe  (spiMisoOe)
  );

  spi_stat_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .siSync  (siSync),
    .busyIn  (storeBusy),
    .rxTail  (rxTail),
    .txMsb   (spiMiso),
    .wenQ    (wenQ),
    .bpOut   (protBp),
    .wpenOut (protWpen)
  );

endmodule

// File: tb/test_spi_status_ctl.sv
`timescale 1ns/1ps
module test_spi_status_ctl;

  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       csN = 1'b1;
  logic       mosi = 1'b0;
  logic       busy = 1'b0;
  logic       miso;
  logic       oe;
  logic [1:0] bp;
  logic       wpen;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  spi_status_ctl i_spi_status_ctl (
    .clk(clk), .rstN(rstN), .spiSck(sck), .spiCsN(csN), .spiMosi(mosi),
    .storeBusy(busy), .spiMiso(miso), .spiMisoOe(oe), .protBp(bp), .protWpen(wpen)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input int nBits, input logic [31:0] txv,
                       output logic [31:0] rxv, output int oeCnt);
    rxv = '0;
    oeCnt = 0;
    @(negedge clk);
    csN = 1'b0;
    for (int i = nBits - 1; i >= 0; i--) begin
      mosi = txv[i];
      repeat (H) @(negedge clk);
      rxv = {rxv[30:0], miso};
      if (oe) oeCnt++;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic readStat(output logic [7:0] val, output int oeCnt);
    logic [31:0] rx;
    frame(16, 32'h0500, rx, oeCnt);
    val = rx[7:0];
  endtask

  task automatic sendWren();
    logic [31:0] rx;
    int o;
    frame(8, 32'h06, rx, o);
  endtask

  task automatic sendWrsr(input logic [7:0] d);
    logic [31:0] rx;
    int o;
    frame(16, {16'h0, 8'h01, d}, rx, o);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  st;
    logic [31:0] rx;
    int          o;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe after reset", oe, 0);
    chk("R1 protBp after reset", bp, 0);
    chk("R1 protWpen after reset", wpen, 0);
    readStat(st, o);
    chk("R1 status after reset", st, 8'h00);
    chk("R5 oe cycles in read", o, 8);

    // R3 busy reflected in bit 0
    busy = 1'b1;
    readStat(st, o);
    chk("R3 busy reads ready bit", st, 8'h01);
    busy = 1'b0;

    // R8 locked write
    sendWrsr(8'hFF);
    readStat(st, o);
    chk("R8 write refused without latch", st, 8'h00);
    chk("R12 protBp unchanged", bp, 0);

    // R6 write enable
    sendWren();
    readStat(st, o);
    chk("R6 latch set", st, 8'h02);
    busy = 1'b1;
    readStat(st, o);
    chk("R3 busy with latch", st, 8'h03);
    busy = 1'b0;

    // R3 write cannot set ready bit; R7 R9 R12 exhaustive sweep
    for (int d = 0; d < 256; d++) begin
      sendWren();
      sendWrsr(d[7:0]);
      readStat(st, o);
      chk("R7 R9 masked write readback", st, d[7:0] & 8'h8C);
      chk("R12 protBp mirror", bp, d[3:2]);
      chk("R12 protWpen mirror", wpen, d[7]);
    end

    // R4 R5 longer read: status in first byte only, oe off after
    frame(24, 32'h050000, rx, o);
    chk("R4 status MSB first", rx[15:8], 8'h8C);
    chk("R5 oe limited to 8 bits", o, 8);

    // R10 truncated and overlong writes
    sendWren();
    frame(12, 32'h010, rx, o);
    readStat(st, o);
    chk("R10 truncated write ignored", st, 8'h8E);
    frame(17, {15'h0, 8'h01, 8'h00, 1'b0}, rx, o);
    readStat(st, o);
    chk("R10 overlong write ignored", st, 8'h8E);
    sendWrsr(8'h00);
    readStat(st, o);
    chk("R9 latch cleared by write", st, 8'h00);
    frame(5, 32'h0, rx, o);
    readStat(st, o);
    chk("R10 truncated enable ignored", st, 8'h00);
    frame(9, 32'h00C, rx, o);
    readStat(st, o);
    chk("R10 overlong enable ignored", st, 8'h00);

    // R2 aborted read then full read restarts decoding
    frame(4, 32'h0, rx, o);
    sendWren();
    readStat(st, o);
    chk("R2 decode restarts at cs fall", st, 8'h02);

    // R11 unknown opcodes
    frame(16, 32'hA5FF, rx, o);
    chk("R11 no output for unknown opcode", o, 0);
    frame(16, 32'h04FF, rx, o);
    chk("R11 no output for opcode 04", o, 0);
    readStat(st, o);
    chk("R11 state untouched", st, 8'h02);

    // R1 reset clears everything
    sendWrsr(8'hFF);
    chk("R12 wpen before reset", wpen, 1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 protBp after reset pulse", bp, 0);
    chk("R1 protWpen after reset pulse", wpen, 0);
    readStat(st, o);
    chk("R1 status after reset pulse", st, 8'h00);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule